// File: doc/BRIEF.md
# Dual-Source Trace Line Packer

This block sits between two independent execution sources and a small on-chip trace RAM. Source A is a CPU with 24-bit addresses. Source B is a co-processor with 16-bit addresses. The block turns their change-of-flow events, or in detail mode their data accesses, into 64-bit lines and writes each line to the RAM at a running line index. The trace RAM, arming, triggering and readout all live outside this block.

A source-select input chooses what is traced: source A only, source B only, or both. A detail input chooses between change-of-flow tracing and data-access tracing. In single-source change-of-flow tracing, each record is only half a line wide. Two records captured at different times therefore share one line, and the low bit of the entry counter shows whether a first half is waiting. In every other setting, each trace event writes exactly one line.

Top module: `dual_trace_packer`

## Requirements
- R1: An asynchronous active-low reset, released through a two-stage synchronizer, clears the entry counter, the wrap flag, the write strobe and any waiting half line.
- R2: With source A only in change-of-flow mode, a record is the 32-bit half {valid=1, info[6:0], address[23:0]}. The first record of a line is held in bytes 3..0 with no write. The second record goes to bytes 7..4 and causes the line write.
- R3: With source B only in change-of-flow mode, a record is the 32-bit half {valid=1, info[6:0], 8'h00, address[15:0]}, paired into lines as in R2.
- R4: In single-source change-of-flow mode, the entry counter rises by one per record. In all other modes, counter bit 0 stays 0 and the line index (counter bits above bit 0) rises by one per written line. The index presented with a write is the index before the advance.
- R5: With both sources in change-of-flow mode, each cycle with a change-of-flow on either source writes one line with source A's half in bytes 7..4 and source B's half in bytes 3..0. A source without a change-of-flow in that cycle has its half written as all zero, so its valid bit (bit 63 for A, bit 31 for B) is 0. Simultaneous events give two valid halves in one line.
- R6: In detail mode, each traced access writes one line. Byte 7 holds {1, source (0=A, 1=B), write, word, 4'b0000}. Bytes 6..4 hold the A address, bytes 3..2 hold the data, and bytes 1..0 hold the B address. The address field of the source not recorded is zero.
- R7: For a word access, data[15:8] (the byte at the lower address) goes to byte 3 and data[7:0] goes to byte 2. For a single-byte access, data[7:0] goes to byte 2 and byte 3 is zero.
- R8: In detail mode with both sources selected, an A access has priority. A B access in the same cycle is dropped, and the next idle cycle writes nothing.
- R9: Strobes that the current mode does not trace are ignored and change neither the counter nor the write outputs. These are access strobes in change-of-flow mode, change-of-flow strobes in detail mode, and the other source's strobes in a single-source mode.
- R10: After a write at index DEPTH-1, the line index returns to 0. The wrap flag is set by that write and stays set until reset.
- R11: The write strobe, index and data are registered. They appear in the cycle after the triggering strobe, and the write strobe lasts one cycle per line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_sel_i | input | 2 | 00 A only, 01 B only, 1x both |
| detail_i | input | 1 | 1 traces data accesses, 0 traces change-of-flow |
| a_cof_i | input | 1 | Source A change-of-flow strobe |
| a_cof_addr_i | input | 24 | Source A change-of-flow address |
| a_info_i | input | 7 | Source A info bits |
| b_cof_i | input | 1 | Source B change-of-flow strobe |
| b_cof_addr_i | input | 16 | Source B change-of-flow address |
| b_info_i | input | 7 | Source B info bits |
| a_acc_i | input | 1 | Source A data-access strobe |
| a_acc_addr_i | input | 24 | Source A access address |
| a_acc_data_i | input | 16 | Source A access data, [15:8] at the lower address |
| a_acc_word_i | input | 1 | Source A access is a word |
| a_acc_wr_i | input | 1 | Source A access is a write |
| b_acc_i | input | 1 | Source B data-access strobe |
| b_acc_addr_i | input | 16 | Source B access address |
| b_acc_data_i | input | 16 | Source B access data, [15:8] at the lower address |
| b_acc_word_i | input | 1 | Source B access is a word |
| b_acc_wr_i | input | 1 | Source B access is a write |
| wr_en_o | output | 1 | Trace RAM write strobe |
| wr_idx_o | output | 6 | Trace RAM line index |
| wr_data_o | output | 64 | Trace RAM line data |
| entry_cnt_o | output | 7 | Entry counter; bit 0 marks a waiting half line |
| wrapped_o | output | 1 | Sticky flag: the line index has wrapped |

## Verification
Two kinds of event can land in the same cycle: a change-of-flow on both sources while both are traced, and a data access on both sources in detail mode. The bench raises both strobes on the same clock edge. In change-of-flow mode it expects a single line with both valid halves and a single index step. In detail mode it expects only the A access in the line, followed by an idle cycle with no write, which shows that the B access was dropped and not deferred. A second coincidence falls at the wrap boundary: the write at the last index must raise the wrap flag in the same cycle, and the next write must use index 0.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int unsigned LINE_W = 64;
  localparam int unsigned HALF_W = LINE_W / 2;
  localparam int unsigned INFO_W = 7;
  localparam int unsigned DATA_W = 16;

  typedef enum logic [1:0] {
    SEL_A    = 2'b00,
    SEL_B    = 2'b01,
    SEL_BOTH = 2'b10,
    SEL_ALT  = 2'b11
  } src_sel_e;

  // Detail data field: a byte access lands in the low byte and the high byte is zeroed.
  function automatic logic [DATA_W-1:0] data_field(input logic [DATA_W-1:0] d, input logic word);
    data_field = word ? d : {8'h00, d[7:0]};
  endfunction
endpackage

// File: rtl/trc_rec_fmt.sv
module trc_rec_fmt
  import trc_pkg::*;
#(
  parameter int unsigned A_ADDR_W = 24,
  parameter int unsigned B_ADDR_W = 16
) (
  input  logic [INFO_W-1:0]   a_info_i,
  input  logic [A_ADDR_W-1:0] a_cof_addr_i,
  input  logic [INFO_W-1:0]   b_info_i,
  input  logic [B_ADDR_W-1:0] b_cof_addr_i,
  input  logic [A_ADDR_W-1:0] a_acc_addr_i,
  input  logic [DATA_W-1:0]   a_acc_data_i,
  input  logic                a_acc_word_i,
  input  logic                a_acc_wr_i,
  input  logic [B_ADDR_W-1:0] b_acc_addr_i,
  input  logic [DATA_W-1:0]   b_acc_data_i,
  input  logic                b_acc_word_i,
  input  logic                b_acc_wr_i,
  output logic [HALF_W-1:0]   a_half_o,
  output logic [HALF_W-1:0]   b_half_o,
  output logic [LINE_W-1:0]   a_det_o,
  output logic [LINE_W-1:0]   b_det_o
);
  logic [23:0] a_cof_x, a_acc_x;
  logic [15:0] b_cof_x, b_acc_x;

  always_comb begin
    a_cof_x  = 24'(a_cof_addr_i);
    a_acc_x  = 24'(a_acc_addr_i);
    b_cof_x  = 16'(b_cof_addr_i);
    b_acc_x  = 16'(b_acc_addr_i);
    a_half_o = {1'b1, a_info_i, a_cof_x};
    b_half_o = {1'b1, b_info_i, 8'h00, b_cof_x};
    a_det_o  = {1'b1, 1'b0, a_acc_wr_i, a_acc_word_i, 4'h0, a_acc_x,
                data_field(a_acc_data_i, a_acc_word_i), 16'h0000};
    b_det_o  = {1'b1, 1'b1, b_acc_wr_i, b_acc_word_i, 4'h0, 24'h000000,
                data_field(b_acc_data_i, b_acc_word_i), b_acc_x};
  end
endmodule

// File: rtl/trc_line_ctl.sv
module trc_line_ctl
  import trc_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rec_vld_i,
  input  logic              pair_mode_i,
  input  logic [HALF_W-1:0] rec_half_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [LINE_W-1:0] wr_data_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wrap_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HALF_W-1:0] hold_q, hold_d;
  logic              wr_en_q, wr_en_d, wrap_q, wrap_d;
  logic [IDX_W-1:0]  wr_idx_q, wr_idx_d, idx_cur, idx_nxt;
  logic [LINE_W-1:0] wr_data_q, wr_data_d;
  logic              data_ce;

  always_comb begin
    idx_cur   = cnt_q[CNT_W-1:1];
    idx_nxt   = (idx_cur == IDX_W'(DEPTH - 1)) ? '0 : idx_cur + 1'b1;
    cnt_d     = cnt_q;
    hold_d    = hold_q;
    wr_en_d   = 1'b0;
    wr_idx_d  = wr_idx_q;
    wr_data_d = wr_data_q;
    if (rec_vld_i) begin
      if (pair_mode_i && !cnt_q[0]) begin
        hold_d = rec_half_i;
        cnt_d  = cnt_q + 1'b1;
      end else begin
        wr_en_d   = 1'b1;
        wr_idx_d  = idx_cur;
        wr_data_d = pair_mode_i ? {rec_half_i, hold_q} : line_i;
        cnt_d     = {idx_nxt, 1'b0};
      end
    end
    wrap_d  = wrap_q | (wr_en_d && (idx_cur == IDX_W'(DEPTH - 1)));
    data_ce = wr_en_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      hold_q  <= '0;
      wr_en_q <= 1'b0;
      wrap_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      hold_q  <= hold_d;
      wr_en_q <= wr_en_d;
      wrap_q  <= wrap_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else if (data_ce) begin
      wr_idx_q  <= wr_idx_d;
      wr_data_q <= wr_data_d;
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;
  assign cnt_o     = cnt_q;
  assign wrap_o    = wrap_q;

  // R4: after any line write no half line is pending
  p_lsb_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> !cnt_q[0]);
  // R4: the live index sits one past the index just written
  p_idx_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> (cnt_q[CNT_W-1:1] ==
                 ((wr_idx_q == IDX_W'(DEPTH - 1)) ? '0 : wr_idx_q + 1'b1)));
  // R10: wrap flag is sticky
  p_wrap_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_q |=> wrap_q);
  // R11: a write only follows a traced event
  p_wr_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> $past(rec_vld_i));
endmodule

// File: rtl/dual_trace_packer.sv
module dual_trace_packer
  import trc_pkg::*;
#(
  parameter int unsigned DEPTH    = 64,
  parameter int unsigned A_ADDR_W = 24,
  parameter int unsigned B_ADDR_W = 16,
  localparam int unsigned IDX_W   = $clog2(DEPTH),
  localparam int unsigned CNT_W   = IDX_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          src_sel_i,
  input  logic                detail_i,
  input  logic                a_cof_i,
  input  logic [A_ADDR_W-1:0] a_cof_addr_i,
  input  logic [INFO_W-1:0]   a_info_i,
  input  logic                b_cof_i,
  input  logic [B_ADDR_W-1:0] b_cof_addr_i,
  input  logic [INFO_W-1:0]   b_info_i,
  input  logic                a_acc_i,
  input  logic [A_ADDR_W-1:0] a_acc_addr_i,
  input  logic [DATA_W-1:0]   a_acc_data_i,
  input  logic                a_acc_word_i,
  input  logic                a_acc_wr_i,
  input  logic                b_acc_i,
  input  logic [B_ADDR_W-1:0] b_acc_addr_i,
  input  logic [DATA_W-1:0]   b_acc_data_i,
  input  logic                b_acc_word_i,
  input  logic                b_acc_wr_i,
  output logic                wr_en_o,
  output logic [IDX_W-1:0]    wr_idx_o,
  output logic [LINE_W-1:0]   wr_data_o,
  output logic [CNT_W-1:0]    entry_cnt_o,
  output logic                wrapped_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n;
  src_sel_e          sel;
  logic              sel_both, pair_mode, rec_vld, use_a;
  logic [HALF_W-1:0] a_half, b_half, rec_half;
  logic [LINE_W-1:0] a_det, b_det, line;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  trc_rec_fmt #(.A_ADDR_W(A_ADDR_W), .B_ADDR_W(B_ADDR_W)) u_fmt (
    .a_info_i(a_info_i), .a_cof_addr_i(a_cof_addr_i),
    .b_info_i(b_info_i), .b_cof_addr_i(b_cof_addr_i),
    .a_acc_addr_i(a_acc_addr_i), .a_acc_data_i(a_acc_data_i),
    .a_acc_word_i(a_acc_word_i), .a_acc_wr_i(a_acc_wr_i),
    .b_acc_addr_i(b_acc_addr_i), .b_acc_data_i(b_acc_data_i),
    .b_acc_word_i(b_acc_word_i), .b_acc_wr_i(b_acc_wr_i),
    .a_half_o(a_half), .b_half_o(b_half), .a_det_o(a_det), .b_det_o(b_det)
  );

  always_comb begin
    sel       = src_sel_e'(src_sel_i);
    sel_both  = (sel == SEL_BOTH) || (sel == SEL_ALT);
    pair_mode = !detail_i && !sel_both;
    use_a     = (sel == SEL_A) || (sel_both && a_acc_i);
    if (detail_i) begin
      rec_vld = sel_both ? (a_acc_i | b_acc_i) : ((sel == SEL_A) ? a_acc_i : b_acc_i);
      line    = use_a ? a_det : b_det;
    end else begin
      rec_vld = sel_both ? (a_cof_i | b_cof_i) : ((sel == SEL_A) ? a_cof_i : b_cof_i);
      line    = {(a_cof_i ? a_half : '0), (b_cof_i ? b_half : '0)};
    end
    rec_half = (sel == SEL_A) ? a_half : b_half;
  end

  trc_line_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_n), .rec_vld_i(rec_vld), .pair_mode_i(pair_mode),
    .rec_half_i(rec_half), .line_i(line), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o),
    .wr_data_o(wr_data_o), .cnt_o(entry_cnt_o), .wrap_o(wrapped_o)
  );

  // R5: a shared line never carries two invalid halves
  p_one_half_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_o && !$past(detail_i) && $past(src_sel_i[1])) |-> (wr_data_o[63] | wr_data_o[31]));
  // R7: byte accesses leave the high data byte zero
  p_byte_hi_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_o && $past(detail_i) && !wr_data_o[60]) |-> (wr_data_o[31:24] == 8'h00));
  // R6: every detail line carries a set valid bit
  p_det_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_o && $past(detail_i)) |-> wr_data_o[63]);
endmodule

// File: tb/dual_trace_packer_tb.sv
module dual_trace_packer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sel = 2'b00;
  logic        det = 1'b0;
  logic        a_cof = 1'b0, b_cof = 1'b0, a_acc = 1'b0, b_acc = 1'b0;
  logic [23:0] a_cof_addr = '0, a_acc_addr = '0;
  logic [15:0] b_cof_addr = '0, b_acc_addr = '0;
  logic [6:0]  a_info = '0, b_info = '0;
  logic [15:0] a_data = '0, b_data = '0;
  logic        a_word = 1'b0, a_wr = 1'b0, b_word = 1'b0, b_wr = 1'b0;
  logic        wr_en, wrapped;
  logic [5:0]  wr_idx;
  logic [63:0] wr_data;
  logic [6:0]  cnt;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_trace_packer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_sel_i(sel), .detail_i(det),
    .a_cof_i(a_cof), .a_cof_addr_i(a_cof_addr), .a_info_i(a_info),
    .b_cof_i(b_cof), .b_cof_addr_i(b_cof_addr), .b_info_i(b_info),
    .a_acc_i(a_acc), .a_acc_addr_i(a_acc_addr), .a_acc_data_i(a_data),
    .a_acc_word_i(a_word), .a_acc_wr_i(a_wr),
    .b_acc_i(b_acc), .b_acc_addr_i(b_acc_addr), .b_acc_data_i(b_data),
    .b_acc_word_i(b_word), .b_acc_wr_i(b_wr),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .entry_cnt_o(cnt), .wrapped_o(wrapped)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one clock: strobes set at a falling edge are taken at the rising edge, results read at the next falling edge
  task automatic tick();
    @(negedge clk);
    a_cof = 1'b0; b_cof = 1'b0; a_acc = 1'b0; b_acc = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "wr_en", 64'(wr_en), 64'd0);
    chk("R1", "count", 64'(cnt), 64'd0);
    chk("R1", "wrap", 64'(wrapped), 64'd0);
  endtask

  task automatic t_a_pair();
    sel = 2'b00; det = 1'b0;
    a_cof = 1'b1; a_cof_addr = 24'h123456; a_info = 7'h15; tick();
    chk("R2", "no write on first half", 64'(wr_en), 64'd0);
    chk("R4", "count after first", 64'(cnt), 64'd1);
    a_cof = 1'b1; a_cof_addr = 24'hABCDEF; a_info = 7'h2A; tick();
    chk("R2", "write on second", 64'(wr_en), 64'd1);
    chk("R2", "line", wr_data, {8'hAA, 24'hABCDEF, 8'h95, 24'h123456});
    chk("R4", "index", 64'(wr_idx), 64'd0);
    chk("R4", "count", 64'(cnt), 64'd2);
    tick();
    chk("R11", "single-cycle strobe", 64'(wr_en), 64'd0);
  endtask

  task automatic t_b_pair();
    sel = 2'b01; det = 1'b0;
    b_cof = 1'b1; b_cof_addr = 16'h1111; b_info = 7'h01; tick();
    chk("R3", "no write on first half", 64'(wr_en), 64'd0);
    b_cof = 1'b1; b_cof_addr = 16'hF00D; b_info = 7'h7F; tick();
    chk("R3", "line", wr_data, {8'hFF, 8'h00, 16'hF00D, 8'h81, 8'h00, 16'h1111});
    chk("R4", "index", 64'(wr_idx), 64'd1);
    chk("R4", "count", 64'(cnt), 64'd4);
  endtask

  task automatic t_ignore();
    sel = 2'b00; det = 1'b0;
    b_cof = 1'b1; a_acc = 1'b1; tick();
    chk("R9", "foreign strobes no write", 64'(wr_en), 64'd0);
    chk("R9", "foreign strobes count", 64'(cnt), 64'd4);
    det = 1'b1; a_cof = 1'b1; tick();
    chk("R9", "cof in detail no write", 64'(wr_en), 64'd0);
    chk("R9", "cof in detail count", 64'(cnt), 64'd4);
  endtask

  task automatic t_both();
    sel = 2'b10; det = 1'b0;
    a_cof = 1'b1; a_cof_addr = 24'h00AA55; a_info = 7'h03; tick();
    chk("R5", "A only line", wr_data, {8'h83, 24'h00AA55, 32'h0});
    chk("R4", "index A only", 64'(wr_idx), 64'd2);
    chk("R4", "count lsb zero", 64'(cnt), 64'd6);
    b_cof = 1'b1; b_cof_addr = 16'h4242; b_info = 7'h05; tick();
    chk("R5", "B only line", wr_data, {32'h0, 8'h85, 8'h00, 16'h4242});
    a_cof = 1'b1; b_cof = 1'b1; a_cof_addr = 24'h765432; b_cof_addr = 16'h9999;
    a_info = 7'h00; b_info = 7'h40; tick();
    chk("R5", "simultaneous line", wr_data, {8'h80, 24'h765432, 8'hC0, 8'h00, 16'h9999});
    chk("R5", "simultaneous index", 64'(wr_idx), 64'd4);
    chk("R4", "count", 64'(cnt), 64'd10);
  endtask

  task automatic t_detail();
    sel = 2'b00; det = 1'b1;
    a_acc = 1'b1; a_acc_addr = 24'h00C0DE; a_data = 16'h1234; a_word = 1'b1; a_wr = 1'b1; tick();
    chk("R6", "A word write line", wr_data, {8'hB0, 24'h00C0DE, 8'h12, 8'h34, 16'h0});
    chk("R7", "word byte order", 64'(wr_data[31:16]), 64'h1234);
    chk("R4", "index", 64'(wr_idx), 64'd5);
    a_acc = 1'b1; a_acc_addr = 24'h000010; a_data = 16'h77AB; a_word = 1'b0; a_wr = 1'b0; tick();
    chk("R7", "byte access data", wr_data, {8'h80, 24'h000010, 8'h00, 8'hAB, 16'h0});
    sel = 2'b01;
    b_acc = 1'b1; b_acc_addr = 16'hBEEF; b_data = 16'h5566; b_word = 1'b1; b_wr = 1'b0; tick();
    chk("R6", "B word read line", wr_data, {8'hD0, 24'h0, 8'h55, 8'h66, 16'hBEEF});
    chk("R4", "count", 64'(cnt), 64'd16);
  endtask

  task automatic t_det_both();
    sel = 2'b10; det = 1'b1;
    a_acc = 1'b1; a_acc_addr = 24'h0000A0; a_data = 16'h0102; a_word = 1'b1; a_wr = 1'b0;
    b_acc = 1'b1; b_acc_addr = 16'h00B0; b_data = 16'h0304; b_word = 1'b1; b_wr = 1'b1; tick();
    chk("R8", "A wins", wr_data, {8'h90, 24'h0000A0, 8'h01, 8'h02, 16'h0});
    chk("R8", "index", 64'(wr_idx), 64'd8);
    tick();
    chk("R8", "B not deferred", 64'(wr_en), 64'd0);
    chk("R8", "count", 64'(cnt), 64'd18);
  endtask

  task automatic t_wrap();
    sel = 2'b10; det = 1'b0;
    for (int i = 9; i < 64; i++) begin
      a_cof = 1'b1; a_cof_addr = 24'(i); a_info = 7'h00; tick();
      if (i == 62) chk("R10", "no wrap before last", 64'(wrapped), 64'd0);
    end
    chk("R10", "last index", 64'(wr_idx), 64'd63);
    chk("R10", "wrap set", 64'(wrapped), 64'd1);
    a_cof = 1'b1; tick();
    chk("R10", "index returns to 0", 64'(wr_idx), 64'd0);
    chk("R10", "wrap sticky", 64'(wrapped), 64'd1);
  endtask

  task automatic t_reset_partial();
    sel = 2'b00; det = 1'b0;
    a_cof = 1'b1; a_cof_addr = 24'hDEAD00; a_info = 7'h11; tick();
    chk("R1", "pending half before reset", 64'(cnt[0]), 64'd1);
    do_reset();
    chk("R1", "count cleared", 64'(cnt), 64'd0);
    chk("R1", "wrap cleared", 64'(wrapped), 64'd0);
    a_cof = 1'b1; a_cof_addr = 24'h000001; a_info = 7'h01; tick();
    a_cof = 1'b1; a_cof_addr = 24'h000002; a_info = 7'h02; tick();
    chk("R1", "stale half discarded", wr_data, {8'h82, 24'h000002, 8'h81, 24'h000001});
    chk("R1", "index restarts", 64'(wr_idx), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_a_pair();
    t_b_pair();
    t_ignore();
    t_both();
    t_detail();
    t_det_both();
    t_wrap();
    t_reset_partial();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule